// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit with Half Selection

The block is a three-stage integer multiplier for a processor with an XLEN-bit datapath (64 by default). Each cycle it can accept two operands, a two-bit operation code, a signed/unsigned flag and a word-mode flag. One datapath serves three result modes: the upper half of a half-width product, the upper half of a full-width product, and the low XLEN bits of a product with overflow detection. A summary-overflow bit, an opaque operation record and a routing tag travel alongside the operands and come out with their result.

Stage one sign-extends or zero-extends the operands, takes their magnitudes and records whether the product must be negated. Stage two multiplies the magnitudes and applies the sign. Stage three picks the result field and derives overflow. A valid flag moves through the stages. There is no back-pressure, so the unit accepts a new operation on every cycle.

Top module: `mulp_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock edges. A synchronous active-high `rst` clears every valid flag in the pipeline, so `out_valid` is 0 on the three edges after a reset.
- R2: Code 2'b00 multiplies the low half-words (bits [XLEN/2-1:0]) and puts the upper half of that XLEN-bit product into both halves of `out_result`. `in_word` is ignored for this code.
- R3: Code 2'b01 forms the full 2*XLEN-bit product and returns bits [2*XLEN-1:XLEN]. `in_word` is ignored for this code.
- R4: With `in_signed`=1 the operands are two's complement, with the sign at bit XLEN/2-1 in half-word modes and bit XLEN-1 otherwise. With `in_signed`=0 they are unsigned.
- R5: Code 2'b10 with `in_word`=1 returns the full XLEN-bit product of the two low half-words.
- R6: In the mode of R5, both bits of `out_ov` are 1 when product bits [XLEN-1:XLEN/2-1] are not all equal, and both are 0 otherwise.
- R7: Code 2'b10 with `in_word`=0 returns product bits [XLEN-1:0]. Both bits of `out_ov` are 1 when product bits [2*XLEN-1:XLEN-1] are not all equal, and both are 0 otherwise.
- R8: Code 2'b11 returns a zero result with `out_ov`=0. Codes 2'b00 and 2'b01 always give `out_ov`=0.
- R9: `out_so`, `out_rec` and `out_tag` equal the `in_so`, `in_rec` and `in_tag` of the same operation.
- R10: Operations issued on consecutive cycles, or with idle cycles between them, each come out in order with their own result and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_op | input | 2 | Operation code (00 high-half, 01 high-full, 10 low, 11 reserved) |
| in_signed | input | 1 | Operands are two's complement |
| in_word | input | 1 | Half-word mode for the low operation |
| in_so | input | 1 | Summary-overflow bit to forward |
| in_rec | input | REC_W | Opaque operation record |
| in_tag | input | TAG_W | Routing tag |
| out_valid | output | 1 | Result present |
| out_result | output | XLEN | Selected result |
| out_ov | output | 2 | Overflow, same value on both bits |
| out_so | output | 1 | Forwarded summary-overflow bit |
| out_rec | output | REC_W | Forwarded operation record |
| out_tag | output | TAG_W | Forwarded routing tag |

## Verification
The bench builds the unit with XLEN=8, REC_W=4 and TAG_W=2. With this setting the half-word modes become 4x4 products, so every half-word operand pair is covered many times. The full-width modes see every value of the first operand against a spread of second operands, including the most negative value and the all-ones value. The small width also makes it cheap to cover every combination of code, signedness and word flag. Operations are streamed with occasional bubbles and a reset in mid-flight to test alignment and flushing.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

  typedef enum logic [1:0] {
    MOP_HI_HALF = 2'b00,
    MOP_HI_FULL = 2'b01,
    MOP_LO      = 2'b10,
    MOP_RSVD    = 2'b11
  } mop_e;

  localparam int OV_W = 2;

endpackage

// File: rtl/mulp_prep.sv
module mulp_prep
  import mulp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  mop_e             op_i,
  input  logic             sgn_i,
  input  logic             word_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic             vld_o,
  output logic [XLEN-1:0]  mag_a_o,
  output logic [XLEN-1:0]  mag_b_o,
  output logic             neg_o,
  output mop_e             op_o,
  output logic             half_o,
  output logic [CTX_W-1:0] ctx_o
);

  localparam int HALF = XLEN / 2;

  logic            half_c;
  logic [XLEN-1:0] ext_a, ext_b;
  logic            neg_a, neg_b;
  logic [XLEN-1:0] mag_a_c, mag_b_c;

  // Extend a half-word operand to the full width, honouring signedness.
  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                            input logic half, input logic sgn);
    logic [XLEN-1:0] r;
    if (half) begin
      r = {{HALF{sgn & v[HALF-1]}}, v[HALF-1:0]};
    end else begin
      r = v;
    end
    return r;
  endfunction

  always_comb begin
    case (op_i)
      MOP_HI_HALF: half_c = 1'b1;
      MOP_LO:      half_c = word_i;
      default:     half_c = 1'b0;
    endcase
    ext_a   = widen(a_i, half_c, sgn_i);
    ext_b   = widen(b_i, half_c, sgn_i);
    neg_a   = sgn_i & ext_a[XLEN-1];
    neg_b   = sgn_i & ext_b[XLEN-1];
    mag_a_c = neg_a ? (~ext_a + 1'b1) : ext_a;
    mag_b_c = neg_b ? (~ext_b + 1'b1) : ext_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
    mag_a_o <= mag_a_c;
    mag_b_o <= mag_b_c;
    neg_o   <= neg_a ^ neg_b;
    op_o    <= op_i;
    half_o  <= half_c;
    ctx_o   <= ctx_i;
  end

  // R4: unsigned operations never request negation
  assert_unsigned_no_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld_i && !sgn_i)) |-> !neg_o);

endmodule

// File: rtl/mulp_core.sv
module mulp_core
  import mulp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [XLEN-1:0]   mag_a_i,
  input  logic [XLEN-1:0]   mag_b_i,
  input  logic              neg_i,
  input  mop_e              op_i,
  input  logic              half_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              vld_o,
  output logic [2*XLEN-1:0] prod_o,
  output mop_e              op_o,
  output logic              half_o,
  output logic [CTX_W-1:0]  ctx_o
);

  localparam int P_W = 2 * XLEN;

  logic [P_W-1:0] mag_p, sgn_p;

  always_comb begin
    mag_p = P_W'(mag_a_i) * P_W'(mag_b_i);
    sgn_p = neg_i ? (~mag_p + 1'b1) : mag_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
    prod_o <= sgn_p;
    op_o   <= op_i;
    half_o <= half_i;
    ctx_o  <= ctx_i;
  end

  // R4: a zero operand gives a zero product whatever the sign
  assert_zero_operand_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld_i && (mag_a_i == '0 || mag_b_i == '0)))
      |-> (prod_o == '0));

endmodule

// File: rtl/mulp_select.sv
module mulp_select
  import mulp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [2*XLEN-1:0] prod_i,
  input  mop_e              op_i,
  input  logic              half_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              vld_o,
  output logic [XLEN-1:0]   res_o,
  output logic [OV_W-1:0]   ov_o,
  output logic [CTX_W-1:0]  ctx_o
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0]   res_c;
  logic              ov_c;
  logic [HALF:0]     half_span;   // bits [XLEN-1:HALF-1]
  logic [XLEN:0]     full_span;   // bits [2*XLEN-1:XLEN-1]

  assign half_span = prod_i[XLEN-1:HALF-1];
  assign full_span = prod_i[2*XLEN-1:XLEN-1];

  always_comb begin
    res_c = '0;
    ov_c  = 1'b0;
    case (op_i)
      MOP_HI_HALF: res_c = {prod_i[XLEN-1:HALF], prod_i[XLEN-1:HALF]};
      MOP_HI_FULL: res_c = prod_i[2*XLEN-1:XLEN];
      MOP_LO: begin
        res_c = prod_i[XLEN-1:0];
        if (half_i) begin
          ov_c = (|half_span) & ~(&half_span);
        end else begin
          ov_c = (|full_span) & ~(&full_span);
        end
      end
      default: begin
        res_c = '0;
        ov_c  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
    res_o <= res_c;
    ctx_o <= ctx_i;
  end

  for (genvar i = 0; i < OV_W; i++) begin : g_ov
    always_ff @(posedge clk) begin
      ov_o[i] <= ov_c;
    end
  end

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld_i && op_i == MOP_RSVD))
      |-> (res_o == '0 && ov_o == '0));

  assert_high_no_ov_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld_i && op_i != MOP_LO)) |-> (ov_o == '0));

  assert_mirror_halves_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld_i && op_i == MOP_HI_HALF))
      |-> (res_o[XLEN-1:HALF] == res_o[HALF-1:0]));

  assert_ov_agree_R6: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (ov_o[0] == ov_o[OV_W-1]));

endmodule

// File: rtl/mulp_unit.sv
module mulp_unit
  import mulp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REC_W = 16,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [1:0]       in_op,
  input  logic             in_signed,
  input  logic             in_word,
  input  logic             in_so,
  input  logic [REC_W-1:0] in_rec,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_result,
  output logic [1:0]       out_ov,
  output logic             out_so,
  output logic [REC_W-1:0] out_rec,
  output logic [TAG_W-1:0] out_tag
);

  localparam int CTX_W = 1 + REC_W + TAG_W;

  logic [CTX_W-1:0]  ctx_in, ctx1, ctx2, ctx3;
  logic              v1, v2;
  logic [XLEN-1:0]   mag_a, mag_b;
  logic              neg1, half1, half2;
  mop_e              op1, op2;
  logic [2*XLEN-1:0] prod2;
  logic [OV_W-1:0]   ov3;

  assign ctx_in = {in_so, in_rec, in_tag};

  mulp_prep #(.XLEN(XLEN), .CTX_W(CTX_W)) u_prep (
    .clk(clk), .rst(rst), .vld_i(in_valid), .a_i(in_a), .b_i(in_b),
    .op_i(mop_e'(in_op)), .sgn_i(in_signed), .word_i(in_word), .ctx_i(ctx_in),
    .vld_o(v1), .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg1),
    .op_o(op1), .half_o(half1), .ctx_o(ctx1)
  );

  mulp_core #(.XLEN(XLEN), .CTX_W(CTX_W)) u_core (
    .clk(clk), .rst(rst), .vld_i(v1), .mag_a_i(mag_a), .mag_b_i(mag_b),
    .neg_i(neg1), .op_i(op1), .half_i(half1), .ctx_i(ctx1),
    .vld_o(v2), .prod_o(prod2), .op_o(op2), .half_o(half2), .ctx_o(ctx2)
  );

  mulp_select #(.XLEN(XLEN), .CTX_W(CTX_W)) u_sel (
    .clk(clk), .rst(rst), .vld_i(v2), .prod_i(prod2), .op_i(op2),
    .half_i(half2), .ctx_i(ctx2),
    .vld_o(out_valid), .res_o(out_result), .ov_o(ov3), .ctx_o(ctx3)
  );

  assign out_ov = ov3;
  assign {out_so, out_rec, out_tag} = ctx3;

  assert_valid_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(v2)));

  assert_ctx_forward_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && $past(in_valid, 3))
      |-> ({out_so, out_rec, out_tag} == $past(ctx_in, 3)));

endmodule

// File: tb/sim_mulp_unit.sv
module sim_mulp_unit;

  localparam int XLEN  = 8;
  localparam int REC_W = 4;
  localparam int TAG_W = 2;

  typedef struct packed {
    logic       v;
    logic [7:0] r;
    logic [1:0] ov;
    logic       so;
    logic [3:0] rec;
    logic [1:0] tag;
    logic [2:0] kind;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [XLEN-1:0]  in_a = '0, in_b = '0;
  logic [1:0]       in_op = '0;
  logic             in_signed = 1'b0, in_word = 1'b0, in_so = 1'b0;
  logic [REC_W-1:0] in_rec = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_valid;
  logic [XLEN-1:0]  out_result;
  logic [1:0]       out_ov;
  logic             out_so;
  logic [REC_W-1:0] out_rec;
  logic [TAG_W-1:0] out_tag;

  int   checks = 0;
  int   errors = 0;
  int   seq = 0;
  exp_t hist [3];

  always #2 clk = ~clk;

  mulp_unit #(.XLEN(XLEN), .REC_W(REC_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_op(in_op), .in_signed(in_signed), .in_word(in_word), .in_so(in_so),
    .in_rec(in_rec), .in_tag(in_tag), .out_valid(out_valid),
    .out_result(out_result), .out_ov(out_ov), .out_so(out_so),
    .out_rec(out_rec), .out_tag(out_tag)
  );

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5 R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R4";
    endcase
  endfunction

  function automatic logic neq_all(input logic [15:0] v, input int hi, input int lo);
    logic z = 1'b1, o = 1'b1;
    for (int i = lo; i <= hi; i++) begin
      z = z & ~v[i];
      o = o & v[i];
    end
    return !(z || o);
  endfunction

  function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                 input logic [1:0] op, input logic sgn,
                                 input logic w);
    exp_t e;
    int ea, eb;
    logic half;
    logic [15:0] p;
    e = '0;
    e.v = 1'b1;
    half = (op == 2'b00) || (op == 2'b10 && w);
    if (half) begin
      ea = sgn ? int'($signed(a[3:0])) : int'(a[3:0]);
      eb = sgn ? int'($signed(b[3:0])) : int'(b[3:0]);
    end else begin
      ea = sgn ? int'($signed(a)) : int'(a);
      eb = sgn ? int'($signed(b)) : int'(b);
    end
    p = 16'(ea * eb);
    case (op)
      2'b00: begin e.r = {p[7:4], p[7:4]}; e.kind = 3'd0; end
      2'b01: begin e.r = p[15:8]; e.kind = 3'd1; end
      2'b10: begin
        e.r = p[7:0];
        if (w) begin
          e.ov = {2{neq_all(p, 7, 3)}};
          e.kind = 3'd2;
        end else begin
          e.ov = {2{neq_all(p, 15, 7)}};
          e.kind = 3'd3;
        end
      end
      default: begin e.r = '0; e.kind = 3'd4; end
    endcase
    if (sgn && op != 2'b11) e.kind = 3'd5;
    return e;
  endfunction

  task automatic check_out(input exp_t e);
    checks++;
    if (out_valid !== e.v) begin
      errors++;
      $display("FAIL R1 R10 out_valid actual=%b expected=%b", out_valid, e.v);
    end
    if (e.v) begin
      checks++;
      if (out_result !== e.r || out_ov !== e.ov) begin
        errors++;
        $display("FAIL %s result/ov actual=%h/%b expected=%h/%b",
                 req_of(e.kind), out_result, out_ov, e.r, e.ov);
      end
      checks++;
      if (out_so !== e.so || out_rec !== e.rec || out_tag !== e.tag) begin
        errors++;
        $display("FAIL R9 ctx actual=%b/%h/%h expected=%b/%h/%h",
                 out_so, out_rec, out_tag, e.so, e.rec, e.tag);
      end
    end
  endtask

  task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b,
                      input logic [1:0] op, input logic sgn, input logic w);
    exp_t e;
    @(negedge clk);
    check_out(hist[2]);
    hist[2] = hist[1];
    hist[1] = hist[0];
    seq++;
    in_valid  = v;
    in_a      = a;
    in_b      = b;
    in_op     = op;
    in_signed = sgn;
    in_word   = w;
    in_rec    = 4'(seq);
    in_tag    = 2'(seq >> 4);
    in_so     = 1'(seq >> 6);
    e = model(a, b, op, sgn, w);
    e.v   = v;
    e.rec = in_rec;
    e.tag = in_tag;
    e.so  = in_so;
    hist[0] = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) hist[i] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset out_valid actual=%b expected=0", out_valid);
    end
    rst = 1'b0;

    // Sweep all codes, signedness and word flag; R10 bubbles mixed in.
    for (int op = 0; op < 4; op++) begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 2; w++) begin
          for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 20; k++) begin
              step(((a + k) % 11) != 0, 8'(a), 8'((a * 7 + k * 13) % 256),
                   2'(op), 1'(s), 1'(w));
            end
          end
        end
      end
    end

    // R1: reset in flight flushes pending results
    step(1'b1, 8'h12, 8'h34, 2'b01, 1'b0, 1'b0);
    step(1'b1, 8'h80, 8'h80, 2'b01, 1'b1, 1'b0);
    @(negedge clk);
    check_out(hist[2]);
    rst = 1'b1;
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) hist[i] = '0;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 flush out_valid actual=%b expected=0", out_valid);
    end
    // R4 corners, then drain
    step(1'b1, 8'h80, 8'h80, 2'b01, 1'b1, 1'b0);
    step(1'b1, 8'hFF, 8'h01, 2'b10, 1'b1, 1'b0);
    step(1'b1, 8'h08, 8'h08, 2'b10, 1'b1, 1'b1);
    step(1'b1, 8'h0F, 8'h0F, 2'b00, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 8'h00, 2'b00, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule